// File: doc/BRIEF.md
# Coprocessor Load/Store Address Sequencer

The block takes one 32-bit coprocessor load/store instruction at a time, together with the current NZCV flags and the value of the base register it names. When the word carries the coprocessor transfer signature and its condition holds, the block offers the instruction to the coprocessors. If one of them accepts, the block then steps a word-aligned memory address for every word of the transfer. The coprocessor alone decides how long the run is. It signals the final word, and the block then commits the updated base register if the instruction asks for that.

The 8-bit offset counts words. It is scaled to bytes and then added to or subtracted from the base. With pre-indexing the first access uses the offset address. With post-indexing the first access uses the unmodified base. In both modes the write-back value is the offset address. If no coprocessor answers within a fixed number of offer cycles, the block raises a one-cycle undefined-instruction trap and makes no memory access, so software can emulate the operation.

Top module: `cp_xfer_seq`

## Requirements
- R1: After reset, and while idle with no instruction issued, busy_o, cp_req_o, mem_req_o, mem_we_o, wb_en_o and undef_o are all 0.
- R2: An instruction sampled with issue_i starts a transfer only if instr_i[27:25] is 3'b110 and the condition in instr_i[31:28] passes against flags_i = {N,Z,C,V}. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always and 15 never. Any other instruction leaves the block idle and raises no request. A started instruction asserts cp_req_o in the cycle after the issue.
- R3: The first memory address is base_i plus or minus offset*4 when instr_i[24]=1 (pre-indexed), and is base_i unchanged when instr_i[24]=0 (post-indexed). The offset is instr_i[7:0].
- R4: instr_i[23]=1 adds the scaled offset and instr_i[23]=0 subtracts it, in address arithmetic modulo 2^32.
- R5: Each word occupies one cycle with mem_req_o=1. The address rises by 4 after every word until the word on which cp_last_i is 1, and that word is the last one. A cp_last_i on the first word gives a single-word transfer.
- R6: During the words mem_we_o is the inverse of instr_i[20]: a load (1) reads memory and a store (0) writes it.
- R7: In the cycle after the last word, wb_en_o equals instr_i[21]. When it is 1, wb_rn_o is instr_i[19:16] and wb_data_o is base_i plus or minus offset*4, whatever the indexing mode. At no other time is wb_en_o 1.
- R8: If cp_accept_i stays 0 for RESP_WAIT (default 4) offer cycles, undef_o is 1 for exactly one cycle and the block then returns to idle. No memory access and no write-back take place.
- R9: A cp_accept_i in the final offer cycle starts the transfer and the trap does not occur.
- R10: From the offer until the transfer ends, cp_len_o holds instr_i[22], cp_reg_o holds instr_i[15:12] and cp_num_o holds instr_i[11:8]. The length bit has no effect on the addresses.
- R11: issue_i is ignored while busy_o is 1. The running sequence of addresses and write-back is unaffected, and no new offer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction, flags and base are valid this cycle |
| instr_i | input | 32 | Instruction word |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| base_i | input | ADDR_W | Base register value |
| cp_accept_i | input | 1 | A coprocessor accepts the offered instruction |
| cp_last_i | input | 1 | The current word is the last one |
| busy_o | output | 1 | A sequence is in progress |
| cp_req_o | output | 1 | Instruction offered to the coprocessors |
| cp_num_o | output | 4 | Target coprocessor number |
| cp_reg_o | output | 4 | Coprocessor register |
| cp_len_o | output | 1 | Transfer-length hint |
| mem_req_o | output | 1 | Memory access strobe, one per word |
| mem_we_o | output | 1 | 1 = write memory (store), 0 = read (load) |
| mem_addr_o | output | ADDR_W | Word address of the current access |
| wb_en_o | output | 1 | Base write-back enable |
| wb_rn_o | output | 4 | Base register index to write |
| wb_data_o | output | ADDR_W | Updated base value |
| undef_o | output | 1 | Undefined-instruction trap request |

## Verification
Two events can land in the same offer cycle: a coprocessor accepting, and the response window running out. The bench holds cp_accept_i low through three offer cycles and raises it only in the fourth. It then requires memory accesses in the next cycle and no trap at any point. The other collision is the first word and the last word falling in one cycle. cp_last_i is driven on the first access, and the bench checks that the write-back appears in the very next cycle and that no second access is made.

// File: rtl/cp_xfer_pkg.sv
package cp_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFFER,
    ST_XFER,
    ST_WB,
    ST_TRAP
  } state_e;

  typedef struct packed {
    logic       pre;
    logic       up;
    logic       len;
    logic       wb;
    logic       load;
    logic [3:0] rn;
    logic [3:0] crd;
    logic [3:0] cpn;
    logic [7:0] off;
  } cdt_t;

  localparam logic [2:0] CDT_SIG = 3'b110;

  // flags = {N,Z,C,V}
  function automatic logic cond_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cf, v;
    {n, z, cf, v} = f;
    case (c)
      4'h0: cond_pass = z;
      4'h1: cond_pass = !z;
      4'h2: cond_pass = cf;
      4'h3: cond_pass = !cf;
      4'h4: cond_pass = n;
      4'h5: cond_pass = !n;
      4'h6: cond_pass = v;
      4'h7: cond_pass = !v;
      4'h8: cond_pass = cf && !z;
      4'h9: cond_pass = !cf || z;
      4'hA: cond_pass = (n == v);
      4'hB: cond_pass = (n != v);
      4'hC: cond_pass = !z && (n == v);
      4'hD: cond_pass = z || (n != v);
      4'hE: cond_pass = 1'b1;
      default: cond_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cp_xfer_decode.sv
module cp_xfer_decode
  import cp_xfer_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [3:0]  flags_i,
  output cdt_t        fld_o,
  output logic        go_o
);

  logic sig_ok;
  logic cond_ok;

  assign sig_ok  = (instr_i[27:25] == CDT_SIG);
  assign cond_ok = cond_pass(instr_i[31:28], flags_i);
  assign go_o    = sig_ok && cond_ok;

  assign fld_o.pre  = instr_i[24];
  assign fld_o.up   = instr_i[23];
  assign fld_o.len  = instr_i[22];
  assign fld_o.wb   = instr_i[21];
  assign fld_o.load = instr_i[20];
  assign fld_o.rn   = instr_i[19:16];
  assign fld_o.crd  = instr_i[15:12];
  assign fld_o.cpn  = instr_i[11:8];
  assign fld_o.off  = instr_i[7:0];

endmodule

// File: rtl/cp_xfer_agen.sv
module cp_xfer_agen #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              up_i,
  input  logic              pre_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] wb_o
);

  localparam int SH = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] off_b;
  logic [ADDR_W-1:0] moved;
  logic [ADDR_W-1:0] addr_q, wb_q;

  assign off_b = ADDR_W'({off_i, {SH{1'b0}}});
  assign moved = up_i ? (base_i + off_b) : (base_i - off_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wb_q   <= '0;
    end else if (load_i) begin
      addr_q <= pre_i ? moved : base_i;
      wb_q   <= moved;
    end else if (step_i) begin
      addr_q <= addr_q + STEP;
    end
  end

  assign addr_o = addr_q;
  assign wb_o   = wb_q;

  assert_pre_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && pre_i) |=> (addr_o == wb_o));

  assert_post_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pre_i) |=> (addr_o == $past(base_i)));

endmodule

// File: rtl/cp_xfer_ctrl.sv
module cp_xfer_ctrl
  import cp_xfer_pkg::*;
#(
  parameter int RESP_WAIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic go_i,
  input  logic cp_accept_i,
  input  logic cp_last_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic cp_req_o,
  output logic mem_req_o,
  output logic wb_phase_o,
  output logic undef_o
);

  localparam int CW = $clog2(RESP_WAIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(RESP_WAIT - 1);

  state_e state_q;
  logic [CW-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && issue_i && go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (load_o) state_q <= ST_OFFER;
        end
        ST_OFFER: begin
          // acceptance wins over the expiring window
          if (cp_accept_i)            state_q <= ST_XFER;
          else if (cnt_q == CNT_LAST) state_q <= ST_TRAP;
          else                        cnt_q   <= cnt_q + 1'b1;
        end
        ST_XFER: if (cp_last_i) state_q <= ST_WB;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign cp_req_o   = (state_q == ST_OFFER);
  assign mem_req_o  = (state_q == ST_XFER);
  assign step_o     = mem_req_o && !cp_last_i;
  assign wb_phase_o = (state_q == ST_WB);
  assign undef_o    = (state_q == ST_TRAP);

  assert_trap_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |=> (!undef_o && !mem_req_o && !busy_o));

  assert_trap_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> ($past(cp_req_o) && !$past(cp_accept_i)));

  assert_accept_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_o && cp_accept_i) |=> (mem_req_o && !undef_o));

  assert_wb_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_phase_o |-> $past(mem_req_o && cp_last_i));

  assert_offer_from_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cp_req_o) |-> $past(!busy_o && issue_i && go_i));

endmodule

// File: rtl/cp_xfer_seq.sv
module cp_xfer_seq
  import cp_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RESP_WAIT  = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [31:0]       instr_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              cp_accept_i,
  input  logic              cp_last_i,
  output logic              busy_o,
  output logic              cp_req_o,
  output logic [3:0]        cp_num_o,
  output logic [3:0]        cp_reg_o,
  output logic              cp_len_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wb_en_o,
  output logic [3:0]        wb_rn_o,
  output logic [ADDR_W-1:0] wb_data_o,
  output logic              undef_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  cdt_t fld;
  logic go, load, step, wb_phase;
  logic [3:0] rn_q, crd_q, cpn_q;
  logic len_q, wb_q, ld_q;

  cp_xfer_decode u_dec (
    .instr_i (instr_i),
    .flags_i (flags_i),
    .fld_o   (fld),
    .go_o    (go)
  );

  cp_xfer_ctrl #(.RESP_WAIT(RESP_WAIT)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .go_i        (go),
    .cp_accept_i (cp_accept_i),
    .cp_last_i   (cp_last_i),
    .load_o      (load),
    .step_o      (step),
    .busy_o      (busy_o),
    .cp_req_o    (cp_req_o),
    .mem_req_o   (mem_req_o),
    .wb_phase_o  (wb_phase),
    .undef_o     (undef_o)
  );

  cp_xfer_agen #(.ADDR_W(ADDR_W), .OFF_W(8), .WORD_BYTES(WORD_BYTES)) u_agen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .base_i (base_i),
    .off_i  (fld.off),
    .up_i   (fld.up),
    .pre_i  (fld.pre),
    .addr_o (mem_addr_o),
    .wb_o   (wb_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rn_q  <= '0;
      crd_q <= '0;
      cpn_q <= '0;
      len_q <= 1'b0;
      wb_q  <= 1'b0;
      ld_q  <= 1'b0;
    end else if (load) begin
      rn_q  <= fld.rn;
      crd_q <= fld.crd;
      cpn_q <= fld.cpn;
      len_q <= fld.len;
      wb_q  <= fld.wb;
      ld_q  <= fld.load;
    end
  end

  assign cp_num_o = cpn_q;
  assign cp_reg_o = crd_q;
  assign cp_len_o = len_q;
  assign mem_we_o = mem_req_o && !ld_q;
  assign wb_en_o  = wb_phase && wb_q;
  assign wb_rn_o  = rn_q;

  assert_word_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !cp_last_i) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + STEP));

  assert_last_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && cp_last_i) |=> !mem_req_o);

  assert_fields_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(cp_num_o) && $stable(cp_reg_o) && $stable(cp_len_o)));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !wb_en_o && !undef_o && !cp_req_o));

endmodule

// File: tb/cp_xfer_seq_bench.sv
`timescale 1ns/1ps
module cp_xfer_seq_bench;

  typedef struct packed {
    logic [31:0] instr;
    logic [3:0]  flags;
    logic [31:0] base;
    logic [3:0]  nw;
    logic        pass;
    logic [31:0] first;
    logic [31:0] wbv;
  } vec_t;

  localparam int NV = 12;
  localparam logic [136:0] VECS [NV] = '{
    {32'hEDB32510, 4'h0, 32'h00001000, 4'd3, 1'b1, 32'h00001040, 32'h00001040},
    {32'hECE41204, 4'h0, 32'h00002000, 4'd2, 1'b1, 32'h00002000, 32'h00002010},
    {32'hED110108, 4'h0, 32'h00003000, 4'd1, 1'b1, 32'h00002FE0, 32'h00002FE0},
    {32'hEC2703FF, 4'h0, 32'h00004000, 4'd4, 1'b1, 32'h00004000, 32'h00003C04},
    {32'h0DB32510, 4'h4, 32'h00000100, 4'd1, 1'b1, 32'h00000140, 32'h00000140},
    {32'h0DB32510, 4'h0, 32'h00000100, 4'd1, 1'b0, 32'h0, 32'h0},
    {32'hCDB32510, 4'h8, 32'h00000100, 4'd1, 1'b0, 32'h0, 32'h0},
    {32'hADB32510, 4'h9, 32'h00000000, 4'd2, 1'b1, 32'h00000040, 32'h00000040},
    {32'hEFB32510, 4'h0, 32'h00000100, 4'd1, 1'b0, 32'h0, 32'h0},
    {32'hFDB32510, 4'hF, 32'h00000100, 4'd1, 1'b0, 32'h0, 32'h0},
    {32'h8DB32510, 4'h2, 32'h00008000, 4'd1, 1'b1, 32'h00008040, 32'h00008040},
    {32'h9DB32510, 4'h2, 32'h00008000, 4'd1, 1'b0, 32'h0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0] flags = '0;
  logic [31:0] base = '0;
  logic accept = 1'b0;
  logic last = 1'b0;
  logic busy, cp_req, cp_len, mem_req, mem_we, wb_en, undef;
  logic [3:0] cp_num, cp_reg, wb_rn;
  logic [31:0] mem_addr, wb_data;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cp_xfer_seq u_cp_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .instr_i(instr),
    .flags_i(flags), .base_i(base), .cp_accept_i(accept), .cp_last_i(last),
    .busy_o(busy), .cp_req_o(cp_req), .cp_num_o(cp_num), .cp_reg_o(cp_reg),
    .cp_len_o(cp_len), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .wb_en_o(wb_en), .wb_rn_o(wb_rn),
    .wb_data_o(wb_data), .undef_o(undef)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_issue(input logic [31:0] i, input logic [3:0] f, input logic [31:0] b);
    issue = 1'b1; instr = i; flags = f; base = b;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic w, ld;
    w  = v.instr[21];
    ld = v.instr[20];
    do_issue(v.instr, v.flags, v.base);
    chk(cp_req == v.pass, "R2 offer", 32'(cp_req), 32'(v.pass));
    if (!v.pass) begin
      @(negedge clk);
      chk(!busy && !mem_req && !undef, "R2 ignored", {busy, mem_req, undef}, 0);
      return;
    end
    chk(cp_len == v.instr[22] && cp_num == v.instr[11:8] && cp_reg == v.instr[15:12],
        "R10 fields", {cp_len, cp_num, cp_reg}, {v.instr[22], v.instr[11:8], v.instr[15:12]});
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    for (int k = 0; k < int'(v.nw); k++) begin
      chk(mem_req && mem_addr == v.first + 32'(4 * k),
          (k == 0) ? "R3/R4 first address" : "R5 step address", mem_addr, v.first + 32'(4 * k));
      chk(mem_we == !ld, "R6 direction", 32'(mem_we), 32'(!ld));
      last = (k == int'(v.nw) - 1);
      @(negedge clk);
    end
    last = 1'b0;
    chk(!mem_req, "R5 stops at last", 32'(mem_req), 0);
    chk(wb_en == w, "R7 wb enable", 32'(wb_en), 32'(w));
    if (w) begin
      chk(wb_data == v.wbv && wb_rn == v.instr[19:16], "R7 wb value",
          wb_data, v.wbv);
    end
    @(negedge clk);
    chk(!busy && !wb_en, "R7 single wb", {busy, wb_en}, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !cp_req && !mem_req && !mem_we && !wb_en && !undef, "R1 in reset",
        {busy, cp_req, mem_req, mem_we, wb_en, undef}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !cp_req && !mem_req && !wb_en && !undef, "R1 idle",
        {busy, cp_req, mem_req, wb_en, undef}, 0);

    for (int i = 0; i < NV; i++) run_vec(vec_t'(VECS[i]));

    // R8: no coprocessor answers
    do_issue(32'hEDB32510, 4'h0, 32'h1000);
    for (int k = 0; k < 4; k++) begin
      chk(cp_req && !undef && !mem_req, "R8 offer window", {cp_req, undef, mem_req}, 3'b100);
      @(negedge clk);
    end
    chk(undef && !mem_req && !wb_en, "R8 trap", {undef, mem_req, wb_en}, 3'b100);
    @(negedge clk);
    chk(!undef && !busy && !wb_en, "R8 trap one cycle", {undef, busy, wb_en}, 0);

    // R9: accept in the final offer cycle, single-word transfer
    do_issue(32'hEDB32510, 4'h0, 32'h5000);
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk(cp_req, "R9 still offering", 32'(cp_req), 1);
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    chk(mem_req && !undef && mem_addr == 32'h5040, "R9 accept wins", mem_addr, 32'h5040);
    last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    chk(!undef && wb_en && wb_data == 32'h5040, "R9 no trap, wb", wb_data, 32'h5040);
    @(negedge clk);

    // R11: issue during a transfer is ignored
    do_issue(32'hECE41204, 4'h0, 32'h6000);
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    chk(mem_addr == 32'h6000, "R11 word0", mem_addr, 32'h6000);
    issue = 1'b1; instr = 32'hEDB32510; base = 32'h9000;
    @(negedge clk);
    issue = 1'b0;
    chk(mem_req && mem_addr == 32'h6004, "R11 word1 unaffected", mem_addr, 32'h6004);
    last = 1'b1;
    @(negedge clk);
    last = 1'b0;
    chk(wb_en && wb_data == 32'h6010 && wb_rn == 4'd4, "R11 wb unaffected", wb_data, 32'h6010);
    @(negedge clk);
    chk(!cp_req && !busy, "R11 no new offer", {cp_req, busy}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule